// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Register Access

This block is an 8-bit SPI port that sits behind a small processor register bus and can run as bus master or as slave. Software selects the role with a mode bit. In master mode a write to the data register loads the byte directly into the shift register and starts an exchange. The block drives SCK at one quarter of the system clock, shifts MOSI out MSB first, and samples MISO. In slave mode the same shift register moves only while the effective slave select is low. The external SCK, MOSI and slave-select pins pass through a synchronizer first.

At the end of each byte the received value is copied into a separate receive buffer and a completion flag is raised. A data-register read always returns that buffer. While the flag is up, data writes are dropped until software reads the control/status register. The flag clears on the next data-register access after that read. The effective slave select comes either from the pin or from a software chip-select bit, as chosen by a management bit.

Top module: `spiPort`

## Requirements
- R1: After reset the control/status register (address 1) reads 0x00, the select register (address 2) reads 0x00, SCK is low and MISO output enable is low while the pin select is high.
- R2: In master mode (control bit 0 = 1) a data write (address 0) with the flag clear produces exactly 8 SCK pulses at one quarter of the system clock. The byte goes out on MOSI MSB first, with data changing on falling and sampled on rising SCK edges.
- R3: At the end of the eighth bit the completion flag (control/status bit 7) sets, SCK returns low, and the byte sampled from MISO, MSB first, becomes readable at address 0.
- R4: A data read returns the receive buffer, not the shift register; loading a new byte into the shift register leaves the read value unchanged.
- R5: While the flag is set and no status read has occurred since it set, a data write is ignored: no SCK activity, and the flag stays set.
- R6: A status read alone leaves the flag set; a data-register access after a status read clears it.
- R7: After a status read, a data write is accepted: it clears the flag and, in master mode, starts a new exchange.
- R8: With select bit 1 = 0 the effective select follows the pin. With bit 1 = 1 it follows select bit 0, where 0 selects and 1 deselects. In slave mode MISO output enable is high exactly while the effective select is low.
- R9: In slave mode with the select low, the byte on MOSI is captured MSB first on rising SCK. The loaded byte is driven on MISO MSB first, and the flag sets after the eighth falling edge.
- R10: In slave mode with the select high, SCK edges do not shift or count, and the flag does not set.
- R11: Read data appears on the read-data port one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select: 0 data, 1 control/status, 2 select management |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid one cycle after regRd |
| sckOut | output | 1 | Master serial clock |
| mosiOut | output | 1 | Master data out |
| misoIn | input | 1 | Master data in |
| sckIn | input | 1 | Slave serial clock from the bus |
| mosiIn | input | 1 | Slave data in |
| ssPin | input | 1 | External slave-select pin, active low |
| misoOut | output | 1 | Slave data out |
| misoOe | output | 1 | Slave data out enable |

## Verification
The assertions assume that read and write strobes are never raised in the same cycle and that the mode bit is not changed while a master exchange is running. They also assume that the external SCK holds each level for several system clocks, so that synchronized edges are seen one at a time. The stimulus drives one register access per two cycles and holds each slave SCK level for four system clocks. It changes the mode and select settings only between exchanges.

// File: rtl/spiPortPkg.sv
package spiPortPkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_SS   = 2'd2;

  typedef struct packed {
    logic load;    // put write data into the shift register
    logic sample;  // capture the incoming serial bit
    logic shift;   // move the shift register by one bit
    logic finish;  // last shift: copy into receive buffer
  } spiStrobe_t;
endpackage

// File: rtl/spiPortSync.sv
module spiPortSync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= RST_VAL;
    else       stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[i] <= RST_VAL;
        else       stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spiPortPath.sv
module spiPortPath
  import spiPortPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              inBit,
  input  logic              regRd,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] statusByte,
  input  logic [DATA_W-1:0] ssByte,
  output logic              txBit,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] rxBuf;
  logic              smpBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBuf    <= '0;
      smpBit   <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strobe.load)       shiftReg <= regWdata;
      else if (strobe.shift) shiftReg <= {shiftReg[DATA_W-2:0], smpBit};
      if (strobe.sample) smpBit <= inBit;
      if (strobe.finish) rxBuf <= {shiftReg[DATA_W-2:0], smpBit};
      if (regRd) begin
        unique case (regAddr)
          ADDR_DATA: rdData <= rxBuf;
          ADDR_CTRL: rdData <= statusByte;
          ADDR_SS:   rdData <= ssByte;
          default:   rdData <= '0;
        endcase
      end
    end
  end

  assign txBit = shiftReg[DATA_W-1];
endmodule

// File: rtl/spiPortCtrl.sv
module spiPortCtrl
  import spiPortPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              sckSync,
  input  logic              ssSync,
  output spiStrobe_t        strobe,
  output logic              masterMode,
  output logic              busy,
  output logic              doneFlag,
  output logic              statusSeen,
  output logic              swSel,
  output logic              swSs,
  output logic              ssEff,
  output logic              sckOut
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [1:0]       phase;
  logic [CNT_W-1:0] bitCnt;
  logic             sckPrev;
  logic             dataAcc, wrOk, slaveAct, sckRise, sckFall, lastBit;

  assign ssEff    = swSel ? swSs : ssSync;
  assign slaveAct = !masterMode && !ssEff;
  assign sckRise  = slaveAct && sckSync && !sckPrev;
  assign sckFall  = slaveAct && !sckSync && sckPrev;
  assign lastBit  = (bitCnt == LAST_BIT);
  assign dataAcc  = (regWr || regRd) && (regAddr == ADDR_DATA);
  assign wrOk     = regWr && (regAddr == ADDR_DATA) && (!doneFlag || statusSeen);
  assign sckOut   = busy && phase[1];

  always_comb begin
    strobe.load   = wrOk && !busy;
    strobe.sample = busy ? (phase == 2'd1) : sckRise;
    strobe.shift  = busy ? (phase == 2'd3) : sckFall;
    strobe.finish = strobe.shift && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterMode <= 1'b0;
      swSel      <= 1'b0;
      swSs       <= 1'b0;
      busy       <= 1'b0;
      phase      <= '0;
      bitCnt     <= '0;
      sckPrev    <= 1'b0;
      doneFlag   <= 1'b0;
      statusSeen <= 1'b0;
    end else begin
      sckPrev <= sckSync;
      if (regWr && regAddr == ADDR_CTRL) masterMode <= regWdata[0];
      if (regWr && regAddr == ADDR_SS) begin
        swSel <= regWdata[1];
        swSs  <= regWdata[0];
      end
      if (busy) phase <= phase + 2'd1;
      if (strobe.shift) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      if (!masterMode && ssEff) bitCnt <= '0;
      if (strobe.load && masterMode) begin
        busy   <= 1'b1;
        phase  <= '0;
        bitCnt <= '0;
      end
      if (strobe.finish) busy <= 1'b0;
      if (regRd && regAddr == ADDR_CTRL && doneFlag) statusSeen <= 1'b1;
      if (doneFlag && statusSeen && dataAcc) begin
        doneFlag   <= 1'b0;
        statusSeen <= 1'b0;
      end
      if (strobe.finish) begin
        doneFlag   <= 1'b1;
        statusSeen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spiPort.sv
module spiPort
  import spiPortPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              ssPin,
  output logic              misoOut,
  output logic              misoOe
);
  spiStrobe_t  strobe;
  logic        sckSync, mosiSync, ssSync;
  logic        masterMode, busy, doneFlag, statusSeen, swSel, swSs, ssEff;
  logic        txBit, inBit;
  logic [DATA_W-1:0] statusByte, ssByte;

  spiPortSync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rstN(rstN),
    .d({sckIn, mosiIn, ssPin}),
    .q({sckSync, mosiSync, ssSync})
  );

  spiPortCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .sckSync(sckSync), .ssSync(ssSync),
    .strobe(strobe), .masterMode(masterMode), .busy(busy),
    .doneFlag(doneFlag), .statusSeen(statusSeen),
    .swSel(swSel), .swSs(swSs), .ssEff(ssEff), .sckOut(sckOut)
  );

  assign statusByte = {doneFlag, {(DATA_W-2){1'b0}}, masterMode};
  assign ssByte     = {{(DATA_W-2){1'b0}}, swSel, swSs};
  assign inBit      = masterMode ? misoIn : mosiSync;

  spiPortPath #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regWdata(regWdata), .inBit(inBit),
    .regRd(regRd), .regAddr(regAddr),
    .statusByte(statusByte), .ssByte(ssByte),
    .txBit(txBit), .rdData(regRdata)
  );

  assign mosiOut = masterMode ? txBit : 1'b0;
  assign misoOut = txBit;
  assign misoOe  = !masterMode && !ssEff;
endmodule

// File: rtl/spiPortChk.sv
module spiPortChk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regAddr,
  input logic       regWr,
  input logic       regRd,
  input logic       sckOut,
  input logic       misoOe,
  input logic       busy,
  input logic       doneFlag,
  input logic       statusSeen,
  input logic       masterMode,
  input logic       swSel,
  input logic       swSs
);
  AST_START_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !busy && !doneFlag && regWr && regAddr == 2'd0) |=> busy); // R2
  AST_SCK_QUIET_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && masterMode) |-> !sckOut); // R3
  AST_WR_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !statusSeen && regWr && regAddr == 2'd0) |=> (doneFlag && $stable(busy))); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !((regWr || regRd) && regAddr == 2'd0)) |=> doneFlag); // R6
  AST_SW_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (swSel && swSs) |-> !misoOe); // R8
endmodule

bind spiPort spiPortChk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
  .sckOut(sckOut), .misoOe(misoOe), .busy(busy), .doneFlag(doneFlag),
  .statusSeen(statusSeen), .masterMode(masterMode), .swSel(swSel), .swSs(swSs)
);

// File: tb/spiPort_tb.sv
module spiPort_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       sckOut, mosiOut, misoIn, misoOut, misoOe;
  logic       sckIn = 1'b0, mosiIn = 1'b0, ssPin = 1'b1;

  int nChecks = 0, nFail = 0, sckRises = 0;
  logic [7:0] slaveTx = '0, slaveRx = '0;
  logic       monValid = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  spiPort u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .sckOut(sckOut), .mosiOut(mosiOut),
    .misoIn(misoIn), .sckIn(sckIn), .mosiIn(mosiIn), .ssPin(ssPin),
    .misoOut(misoOut), .misoOe(misoOe)
  );

  // bench-side slave for master exchanges
  assign misoIn = slaveTx[7];
  always @(negedge sckOut) slaveTx <= {slaveTx[6:0], 1'b0};
  always @(posedge sckOut) begin
    slaveRx <= {slaveRx[6:0], mosiOut};
    sckRises <= sckRises + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read data is due one cycle after the strobe (R11)
  always @(posedge clk) monValid <= regRd;
  always @(negedge clk) begin
    if (monValid) begin
      if (expQ.size() == 0) check("R11 unexpected read", 32'(regRdata), 32'hFFFF);
      else check(tagQ.pop_front(), 32'(regRdata), 32'(expQ.pop_front()));
    end
  end

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slaveXfer(input logic [7:0] txByte, output logic [7:0] rxByte);
    for (int i = 7; i >= 0; i--) begin
      mosiIn = txByte[i];
      idle(4);
      rxByte[i] = misoOut;
      sckIn = 1'b1;
      idle(4);
      sckIn = 1'b0;
      idle(4);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int startRises;
    logic [7:0] got;
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 sckOut", 32'(sckOut), 0);
    check("R1 misoOe", 32'(misoOe), 0);
    rdReg(2'd1, 8'h00, "R1 ctrl reset");
    rdReg(2'd2, 8'h00, "R1 select reset");

    // R2/R3 first master exchange
    wrReg(2'd1, 8'h01);
    slaveTx = 8'h3C;
    startRises = sckRises;
    wrReg(2'd0, 8'hA5);
    idle(40);
    check("R2 sck pulse count", 32'(sckRises - startRises), 8);
    check("R2 MOSI byte", 32'(slaveRx), 32'hA5);
    check("R3 sck low after end", 32'(sckOut), 0);

    // R5 write while flag set and no status read
    startRises = sckRises;
    wrReg(2'd0, 8'hFF);
    idle(40);
    check("R5 no sck after inhibited write", 32'(sckRises - startRises), 0);
    rdReg(2'd1, 8'h81, "R5 flag kept / R3 flag set");
    rdReg(2'd1, 8'h81, "R6 status read alone keeps flag");
    rdReg(2'd0, 8'h3C, "R3 received byte");
    rdReg(2'd1, 8'h01, "R6 flag cleared by data access");

    // R7 write accepted after status read
    slaveTx = 8'hE7;
    wrReg(2'd0, 8'h5A);
    idle(40);
    check("R2 second MOSI byte", 32'(slaveRx), 32'h5A);
    rdReg(2'd1, 8'h81, "R3 flag set again");
    slaveTx = 8'h18;
    startRises = sckRises;
    wrReg(2'd0, 8'h96);
    idle(40);
    check("R7 sck pulses after status read", 32'(sckRises - startRises), 8);
    check("R7 MOSI byte", 32'(slaveRx), 32'h96);
    rdReg(2'd1, 8'h81, "R7 new exchange completed");
    rdReg(2'd0, 8'h18, "R7 received byte");
    rdReg(2'd1, 8'h01, "R6 flag cleared");

    // R4 buffer vs shift register (slave mode, deselected)
    wrReg(2'd1, 8'h00);
    wrReg(2'd0, 8'hC3);
    rdReg(2'd0, 8'h18, "R4 read returns buffer");

    // R8 select management
    wrReg(2'd2, 8'h02);
    idle(1);
    check("R8 software select low enables MISO", 32'(misoOe), 1);
    wrReg(2'd2, 8'h03);
    idle(1);
    check("R8 software deselect", 32'(misoOe), 0);
    rdReg(2'd2, 8'h03, "R8 select register");
    wrReg(2'd2, 8'h00);
    ssPin = 1'b0;
    idle(4);
    check("R8 pin select low", 32'(misoOe), 1);
    ssPin = 1'b1;
    idle(4);
    check("R8 pin select high", 32'(misoOe), 0);

    // R10 clocks while deselected
    slaveXfer(8'hFF, got);
    idle(6);
    rdReg(2'd1, 8'h00, "R10 no flag while deselected");

    // R9 slave exchange
    ssPin = 1'b0;
    idle(4);
    slaveXfer(8'h69, got);
    idle(6);
    check("R9 MISO byte (R10 shift register untouched)", 32'(got), 32'hC3);
    rdReg(2'd1, 8'h80, "R9 flag set");
    rdReg(2'd0, 8'h69, "R9 MOSI byte received");
    ssPin = 1'b1;
    idle(4);
    check("R11 scoreboard drained", 32'(expQ.size()), 0);
    finishRun();
  end
endmodule